// File: doc/BRIEF.md
# Double-Buffered Eight-Channel Converter Code Bank

This block is the digital front end of an eight-channel, 14-bit converter. A parallel bus carries a 14-bit word and a 3-bit channel address. A write strobe, qualified by chip-select, captures the word into the addressed channel's first-stage (staging) register. A separate load strobe copies every staging register into its second-stage (code) register in the same clock cycle. The code registers drive the converter codes, so all channels can change together.

All controls are active low and are sampled on the rising edge of the system clock. Each register stage is modelled as a clocked register, not as a transparent latch. The stage is open on every edge where its controls are low and closed otherwise. When chip-select, write and load are all low together, the bus word reaches the addressed channel's code in a single edge. This is the flow-through path.

Codes are offset binary. A format input can treat bus words as two's complement, and the block then converts them before storing them. A clear input forces every output code to the midscale (zero-volt) value but leaves both register stages untouched. Releasing clear therefore brings back the codes that were held before.

Top module: `dac_dbl_bank`

## Requirements
- R1: Address value n selects channel n, and channel n's code appears on `dac_code[n*14 +: 14]`.
- R2: A channel's staging register takes the converted bus word on a clock edge where `cs_n` and `wr_n` are both low and `addr` selects it. On any edge where `cs_n` or `wr_n` is high, it holds its value.
- R3: On a clock edge where `ld_n` is low, each code register takes the value its staging register has after that edge. On an edge where `ld_n` is high, every code register holds.
- R4: When `cs_n`, `wr_n` and `ld_n` are all low at an edge, the addressed channel's output code equals that cycle's converted bus word right after that edge.
- R5: A single edge with `ld_n` low updates all eight code registers at the same time.
- R6: While `clr_n` is low, every output reads 14'h2000 in the same cycle, with no clock edge needed. Clear changes neither register stage, so raising `clr_n` shows the held codes again.
- R7: With `twos_sel` = 1, the stored word is the bus word with bit 13 inverted (two's complement plus 8192). With `twos_sel` = 0, the bus word is stored unchanged.
- R8: A write changes only the addressed channel's staging register. At most one channel is written per edge.
- R9: A synchronous reset (`rst` high at an edge) sets every staging and code register to 14'h2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip-select, active low |
| wr_n | input | 1 | Write strobe for the staging registers, active low |
| ld_n | input | 1 | Load strobe for the code registers, active low |
| clr_n | input | 1 | Output clear to midscale, active low, non-destructive |
| twos_sel | input | 1 | 1: bus word is two's complement; 0: offset binary |
| addr | input | 3 | Channel address |
| bus_data | input | 14 | Bus data word |
| dac_code | output | 112 | Eight 14-bit output codes, channel 0 in the low bits |

## Verification
Write, load and clear can all act in the same cycle. The sharpest case is a write that lands on an edge where load is also low while clear is held. In that case the addressed code must take the new word, the other channels must take their staging values, and the outputs must still read midscale until clear is released.

The random phase drives all four controls independently, so these overlaps occur often. The directed sequences create each overlap on purpose. After every edge, a bench model of both register stages predicts all eight codes, and the bench compares them with the outputs.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
   localparam int unsigned CODE_W_DEF = 14;
   localparam int unsigned CHANNELS_DEF = 8;

   // Midscale (zero-volt) offset-binary code for a given width
   function automatic logic [31:0] midscale(input int unsigned w);
      return 32'd1 << (w - 1);
   endfunction
endpackage

// File: rtl/dac_word_fmt.sv
module dac_word_fmt #(
   parameter int unsigned W = 14
) (
   input  logic         twos_sel,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (W < 2) begin : g_bad_w
         $error("dac_word_fmt: W must be at least 2");
      end
   endgenerate

   // Adding half-scale to a two's-complement word flips only the sign bit
   always_comb begin
      dout = din;
      if (twos_sel) dout[W-1] = ~din[W-1];
   end
endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
   parameter int unsigned W      = 14,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned IDX    = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              ld_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      word,
   output logic              wr_hit,
   output logic [W-1:0]      out_q
);
   localparam logic [W-1:0] MID = W'(dac_bank_pkg::midscale(W));
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(IDX);

   logic [W-1:0] in_q;
   logic [W-1:0] in_nxt;

   assign wr_hit = !cs_n && !wr_n && (addr == MY_ADDR);
   assign in_nxt = wr_hit ? word : in_q;

   // Staging stage
   always_ff @(posedge clk) begin
      if (rst) in_q <= MID;
      else     in_q <= in_nxt;
   end

   // Code stage: the next staging value feeds it, which gives flow-through
   always_ff @(posedge clk) begin
      if (rst)        out_q <= MID;
      else if (!ld_n) out_q <= in_nxt;
   end

   p_in_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (cs_n || wr_n) |=> $stable(in_q));
   p_out_hold_r3: assert property (@(posedge clk) disable iff (rst)
      ld_n |=> $stable(out_q));
   p_load_copy_r5: assert property (@(posedge clk) disable iff (rst)
      (!ld_n && (cs_n || wr_n)) |=> out_q == $past(in_q));
   p_flow_thru_r4: assert property (@(posedge clk) disable iff (rst)
      (!cs_n && !wr_n && !ld_n && addr == MY_ADDR) |=> out_q == $past(word));
endmodule

// File: rtl/dac_dbl_bank.sv
module dac_dbl_bank #(
   parameter int unsigned CODE_W   = 14,
   parameter int unsigned CHANNELS = 8
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           cs_n,
   input  logic                           wr_n,
   input  logic                           ld_n,
   input  logic                           clr_n,
   input  logic                           twos_sel,
   input  logic [$clog2(CHANNELS)-1:0]    addr,
   input  logic [CODE_W-1:0]              bus_data,
   output logic [CHANNELS*CODE_W-1:0]     dac_code
);
   localparam int unsigned ADDR_W = $clog2(CHANNELS);
   localparam logic [CODE_W-1:0] MID = CODE_W'(dac_bank_pkg::midscale(CODE_W));

   generate
      if (CHANNELS < 2 || (1 << ADDR_W) != CHANNELS) begin : g_bad_ch
         $error("dac_dbl_bank: CHANNELS must be a power of two, at least 2");
      end
   endgenerate

   logic [CODE_W-1:0]   word;
   logic [CHANNELS-1:0] hits;

   dac_word_fmt #(.W(CODE_W)) fmt_i (
      .twos_sel(twos_sel), .din(bus_data), .dout(word)
   );

   genvar g;
   generate
      for (g = 0; g < CHANNELS; g++) begin : g_ch
         logic [CODE_W-1:0] held;
         dac_chan #(.W(CODE_W), .ADDR_W(ADDR_W), .IDX(g)) chan_i (
            .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n),
            .addr(addr), .word(word), .wr_hit(hits[g]), .out_q(held)
         );
         // Clear masks the output only; the held code survives
         assign dac_code[g*CODE_W +: CODE_W] = clr_n ? held : MID;
      end
   endgenerate

   p_one_target_r8: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hits));
   p_write_needs_strobe_r2: assert property (@(posedge clk) disable iff (rst)
      (cs_n || wr_n) |-> hits == '0);
endmodule

// File: tb/dac_dbl_bank_tb_top.sv
`timescale 1ns/1ps
module dac_dbl_bank_tb_top;
   localparam int W = 14;
   localparam int N = 8;
   localparam logic [W-1:0] MID = 14'h2000;

   logic clk = 0;
   logic rst, cs_n, wr_n, ld_n, clr_n, twos_sel;
   logic [2:0] addr;
   logic [W-1:0] bus_data;
   logic [N*W-1:0] dac_code;

   int n_run = 0, n_fail = 0;
   logic [W-1:0] m_in [N];
   logic [W-1:0] m_out[N];

   always #2 clk = ~clk;

   dac_dbl_bank dut_i (
      .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n),
      .clr_n(clr_n), .twos_sel(twos_sel), .addr(addr),
      .bus_data(bus_data), .dac_code(dac_code)
   );

   function automatic logic [W-1:0] conv(input logic t, input logic [W-1:0] d);
      return t ? {~d[W-1], d[W-2:0]} : d;
   endfunction

   function automatic logic [N*W-1:0] expect_bus(input logic clr);
      logic [N*W-1:0] e;
      for (int i = 0; i < N; i++) e[i*W +: W] = clr ? m_out[i] : MID;
      return e;
   endfunction

   task automatic check(input string tag);
      logic [N*W-1:0] e;
      e = expect_bus(clr_n);
      n_run++;
      if (dac_code !== e) begin
         n_fail++;
         $display("FAIL %s: dac_code=%h expected=%h", tag, dac_code, e);
      end
   endtask

   // Drive at the falling edge, update the model at the rising edge, check 1 ns later
   task automatic step(input logic c, input logic w, input logic l, input logic cl,
                       input logic t, input logic [2:0] a, input logic [W-1:0] d,
                       input string tag);
      @(negedge clk);
      cs_n = c; wr_n = w; ld_n = l; clr_n = cl; twos_sel = t; addr = a; bus_data = d;
      @(posedge clk);
      if (!c && !w) m_in[a] = conv(t, d);
      if (!l) for (int i = 0; i < N; i++) m_out[i] = m_in[i];
      #1;
      check(tag);
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog: expired, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd7841));
      rst = 1; cs_n = 1; wr_n = 1; ld_n = 1; clr_n = 1; twos_sel = 0;
      addr = 0; bus_data = 0;
      for (int i = 0; i < N; i++) begin m_in[i] = MID; m_out[i] = MID; end
      repeat (3) @(posedge clk);
      #1; check("R9 reset midscale");
      @(negedge clk); rst = 0;

      // R2/R3: write ch3 with load high, output must not move
      step(0, 0, 1, 1, 0, 3'd3, 14'h0123, "R2 write no load");
      step(1, 1, 1, 1, 0, 3'd3, 14'h3FFF, "R3 hold");
      // R2: chip-select high blocks write to ch5
      step(1, 0, 1, 1, 0, 3'd5, 14'h1111, "R2 cs high ignored");
      step(0, 0, 1, 1, 0, 3'd0, 14'h0AAA, "R1 ch0 write");
      step(0, 0, 1, 1, 0, 3'd7, 14'h3555, "R1 ch7 write");
      // R5: single load updates all
      step(1, 1, 0, 1, 0, 3'd0, 14'h0000, "R5 simultaneous load");
      // R4: flow-through
      step(0, 0, 0, 1, 0, 3'd6, 14'h1234, "R4 flow-through");
      step(0, 0, 0, 1, 0, 3'd6, 14'h2345, "R4 flow-through track");
      // R7: two's complement conversion, -1 -> 0x1FFF
      step(0, 0, 0, 1, 1, 3'd2, 14'h3FFF, "R7 twos minus one");
      step(0, 0, 0, 1, 1, 3'd2, 14'h0000, "R7 twos zero");
      // R6: clear then restore, writes under clear kept in registers
      step(1, 1, 1, 0, 0, 3'd0, 14'h0000, "R6 clear midscale");
      step(0, 0, 0, 0, 0, 3'd1, 14'h0777, "R6 write under clear");
      step(1, 1, 1, 1, 0, 3'd0, 14'h0000, "R6 restore");
      // R8: write to ch4 then load, others stay
      step(0, 0, 0, 1, 0, 3'd4, 14'h0042, "R8 single target");

      for (int k = 0; k < 4000; k++) begin
         logic [6:0] r;
         r = 7'($urandom);
         step(r[0], r[1], r[2], r[3] | r[4], r[5], 3'($urandom), 14'($urandom),
              "R3 R4 R6 random");
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule